// File: doc/BRIEF.md
# MSI Request Sequencer with Pending-Bit Deferral

The sequencer takes interrupt requests from user logic, each naming a source port, a function and a vector. For every request it fetches the function's message address, message data and vector mask word from a configuration-access port. If the vector's mask bit is clear, it emits one memory-write TLP with a single data dword on a valid/ready transmit stream. If the mask bit is set, it records the vector as pending through a byte-wide pending-register write port that uses a ready handshake. The vector then waits in a small table.

Waiting vectors are re-read at a programmable interval. Once a re-read shows the mask bit clear, the message is sent and the pending bit is cleared. The table is revisited only between jobs, so a masked vector never stalls new requests for other vectors. A shadow copy of every function's pending word lets each set or clear rewrite a whole byte while keeping the neighbouring bits of that byte.

Top module: `msi_pending_sequencer`

## Requirements
- R1: A request whose vector mask bit reads 0 produces exactly one TLP and no pending-register write.
- R2: A request whose vector mask bit reads 1 first produces a pending write that sets the bit, and then no TLP while the mask keeps reading 1. After a mask read of 0 it produces the TLP, and after that TLP a pending write that clears the bit.
- R3: A pending write drives `pndFunc` with the function, `pndSel` with vector bits [4:3] (selecting pending bits [8*sel+7:8*sel]) and `pndByte` with vector bit [2:0] as its bit position. While `pndReady` is 0 these stay stable and `pndWrite` stays 1. A write completes on the cycle `pndWrite` and `pndReady` are both 1, and `pndWrite` is 0 in the next cycle.
- R4: Each pending write carries the shadow byte with only the target bit changed, so other pending bits in the same byte are kept.
- R5: A request with `reqPort` of 2 or 3 is consumed and dropped: no configuration read, no TLP and no pending write follow.
- R6: A TLP is one beat with `txSop` and `txEop` both 1. Dword k sits at `txData[32k+31:32k]`, and dword 1 is {13'b0, func, 16'h000F}. When address bits [63:32] are zero, the TLP has `txLen`=4, dword 0 is 32'h40000001, dword 2 is {addr[31:2],2'b00}, dword 3 is the data and bits [159:128] are 0. Otherwise it has `txLen`=5, dword 0 is 32'h60000001, dword 2 is addr[63:32], dword 3 is {addr[31:2],2'b00} and dword 4 is the data. While `txReady` is 0, `txValid` and `txData` are held.
- R7: Waiting vectors are re-read at most once each per interval of max(`pollGap`,16) cycles.
- R8: A request for a vector that is already waiting is merged: it causes no extra pending write and no extra TLP.
- R9: While vectors wait for their mask, a request for an unmasked vector is still served with its TLP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Interrupt request valid |
| reqReady | output | 1 | Request accepted when both are high |
| reqPort | input | 2 | Source port; only 0 and 1 may raise messages |
| reqFunc | input | 3 | Function number |
| reqVec | input | 5 | Vector number within the function |
| pollGap | input | 8 | Mask re-read interval in cycles (minimum 16 applied) |
| cfgReq | output | 1 | One-cycle configuration read request |
| cfgFunc | output | 3 | Function whose capability fields are read |
| cfgRspValid | input | 1 | Configuration read response valid |
| cfgRspAddr | input | 64 | Message address from the capability |
| cfgRspData | input | 32 | Message data from the capability |
| cfgRspMask | input | 32 | Vector mask word of the function |
| pndWrite | output | 1 | Pending-register byte write request |
| pndReady | input | 1 | Pending port can take a write |
| pndFunc | output | 3 | Function of the pending write |
| pndSel | output | 2 | Byte select of the pending write |
| pndByte | output | 8 | Byte value written |
| txValid | output | 1 | TLP beat valid |
| txReady | input | 1 | Transmit stream can take the beat |
| txSop | output | 1 | Start of packet |
| txEop | output | 1 | End of packet |
| txLen | output | 3 | Dwords used in txData (4 or 5) |
| txData | output | 160 | Header dwords followed by the data dword |

## Verification
The assertions rely on three things about the environment. Each configuration request gets exactly one response pulse while the sequencer waits for it. `pndReady` and `txReady` may stall for any number of cycles but must eventually rise. The caller keeps a request stable until it is accepted. The bench's configuration responder answers every read one cycle after the request with a single pulse. The ready inputs and the request fields change only just after a rising edge, and a request is dropped only after the edge that accepts it.

// File: rtl/msi_seq_pkg.sv
package msi_seq_pkg;
  localparam int FUNC_W = 3;
  localparam int VEC_W  = 5;
  localparam int SEL_W  = VEC_W - 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CFG, ST_WAIT, ST_PND, ST_TX
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadJob;
    logic [FUNC_W-1:0] jobFunc;
    logic [VEC_W-1:0]  jobVec;
    logic              capCfg;
    logic              pndClr;
    logic              pndDone;
  } seqStrobe_t;
endpackage

// File: rtl/msi_seq_dp.sv
module msi_seq_dp
  import msi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [63:0]       cfgRspAddr,
  input  logic [31:0]       cfgRspData,
  input  logic [31:0]       cfgRspMask,
  output logic              rspMaskBit,
  output logic [FUNC_W-1:0] jobFunc,
  output logic [VEC_W-1:0]  jobVec,
  output logic [SEL_W-1:0]  pndSel,
  output logic [7:0]        pndByte,
  output logic [159:0]      txData,
  output logic [2:0]        txLen
);
  localparam int NFUNC = 1 << FUNC_W;
  localparam int PW    = 1 << VEC_W;

  logic [63:0]   addrQ;
  logic [31:0]   dataQ;
  logic [PW-1:0] shadowQ [NFUNC];
  logic [7:0]    curByte, bitMask;
  logic          is4;
  logic [31:0]   dw1;

  assign jobFunc    = strb.loadJob ? jobFuncReg : jobFuncReg;
  logic [FUNC_W-1:0] jobFuncReg;
  logic [VEC_W-1:0]  jobVecReg;
  assign jobVec     = jobVecReg;
  assign rspMaskBit = cfgRspMask[jobVecReg];
  assign pndSel     = jobVecReg[VEC_W-1:3];
  assign bitMask    = 8'b1 << jobVecReg[2:0];
  assign curByte    = shadowQ[jobFuncReg][{pndSel, 3'b000} +: 8];
  assign pndByte    = strb.pndClr ? (curByte & ~bitMask) : (curByte | bitMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      jobFuncReg <= '0;
      jobVecReg  <= '0;
      addrQ      <= '0;
      dataQ      <= '0;
      for (int f = 0; f < NFUNC; f++) shadowQ[f] <= '0;
    end else begin
      if (strb.loadJob) begin
        jobFuncReg <= strb.jobFunc;
        jobVecReg  <= strb.jobVec;
      end
      if (strb.capCfg) begin
        addrQ <= cfgRspAddr;
        dataQ <= cfgRspData;
      end
      if (strb.pndDone) shadowQ[jobFuncReg][{pndSel, 3'b000} +: 8] <= pndByte;
    end
  end

  // one-dword memory write; header size chosen by upper address bits
  assign is4 = |addrQ[63:32];
  assign dw1 = {13'd0, jobFuncReg, 16'h000F};
  always_comb begin
    if (is4) begin
      txLen  = 3'd5;
      txData = {dataQ, addrQ[31:2], 2'b00, addrQ[63:32], dw1, 32'h6000_0001};
    end else begin
      txLen  = 3'd4;
      txData = {32'd0, dataQ, addrQ[31:2], 2'b00, dw1, 32'h4000_0001};
    end
  end
endmodule

// File: rtl/msi_seq_ctl.sv
module msi_seq_ctl
  import msi_seq_pkg::*;
#(
  parameter int TBL_DEPTH = 8,
  parameter int NUM_PORTS = 2,
  parameter int GAP_W     = 8,
  parameter int MIN_GAP   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqPort,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [VEC_W-1:0]  reqVec,
  input  logic [GAP_W-1:0]  pollGap,
  input  logic              cfgRspValid,
  input  logic              rspMaskBit,
  input  logic [FUNC_W-1:0] jobFunc,
  input  logic [VEC_W-1:0]  jobVec,
  input  logic              pndReady,
  input  logic              txReady,
  output logic              cfgReq,
  output logic              pndWrite,
  output logic              txValid,
  output seqStrobe_t        strb
);
  localparam int IDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;

  seqState_t         stateQ, stateD;
  logic              fromTblQ, clrQ;
  logic [IDX_W-1:0]  idxQ;
  logic [TBL_DEPTH-1:0] tblValid, tblDue;
  logic [FUNC_W-1:0] tblFunc [TBL_DEPTH];
  logic [VEC_W-1:0]  tblVec  [TBL_DEPTH];
  logic [GAP_W-1:0]  gapCntQ, gapEff;
  logic              tick, hit, haveFree, anyDue, portOk;
  logic              startTbl, startNew, acceptReq;
  logic [IDX_W-1:0]  freeIdx, dueIdx;

  always_comb begin
    hit = 1'b0; haveFree = 1'b0; anyDue = 1'b0;
    freeIdx = '0; dueIdx = '0;
    for (int i = TBL_DEPTH - 1; i >= 0; i--) begin
      if (!tblValid[i]) begin haveFree = 1'b1; freeIdx = IDX_W'(i); end
      if (tblValid[i] && tblDue[i]) begin anyDue = 1'b1; dueIdx = IDX_W'(i); end
      if (tblValid[i] && tblFunc[i] == reqFunc && tblVec[i] == reqVec) hit = 1'b1;
    end
  end

  assign portOk    = 32'(reqPort) < NUM_PORTS;
  assign reqReady  = (stateQ == ST_IDLE) && !anyDue && (!portOk || hit || haveFree);
  assign acceptReq = reqValid && reqReady;
  assign startNew  = acceptReq && portOk && !hit;
  assign startTbl  = (stateQ == ST_IDLE) && anyDue;

  assign cfgReq   = (stateQ == ST_CFG);
  assign pndWrite = (stateQ == ST_PND);
  assign txValid  = (stateQ == ST_TX);

  always_comb begin
    strb         = '0;
    strb.loadJob = startNew || startTbl;
    strb.jobFunc = startTbl ? tblFunc[dueIdx] : reqFunc;
    strb.jobVec  = startTbl ? tblVec[dueIdx]  : reqVec;
    strb.capCfg  = (stateQ == ST_WAIT) && cfgRspValid;
    strb.pndClr  = clrQ;
    strb.pndDone = pndWrite && pndReady;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (strb.loadJob) stateD = ST_CFG;
      ST_CFG:  stateD = ST_WAIT;
      ST_WAIT: if (cfgRspValid) begin
        if (rspMaskBit) stateD = fromTblQ ? ST_IDLE : ST_PND;
        else            stateD = ST_TX;
      end
      ST_PND:  if (pndReady) stateD = ST_IDLE;
      ST_TX:   if (txReady) stateD = fromTblQ ? ST_PND : ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE; fromTblQ <= 1'b0; clrQ <= 1'b0; idxQ <= '0;
    end else begin
      stateQ <= stateD;
      if (strb.loadJob) begin
        fromTblQ <= startTbl;
        clrQ     <= startTbl;
        idxQ     <= dueIdx;
      end
    end
  end

  // poll interval timer
  assign gapEff = (pollGap < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : pollGap;
  assign tick   = gapCntQ >= gapEff - 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCntQ <= '0; tblValid <= '0; tblDue <= '0;
      for (int i = 0; i < TBL_DEPTH; i++) begin tblFunc[i] <= '0; tblVec[i] <= '0; end
    end else begin
      gapCntQ <= tick ? '0 : gapCntQ + 1'b1;
      if (tick) tblDue <= tblValid;
      if (startTbl) tblDue[dueIdx] <= 1'b0;
      if (strb.pndDone && !clrQ) begin
        tblValid[freeIdx] <= 1'b1;
        tblDue[freeIdx]   <= 1'b0;
        tblFunc[freeIdx]  <= jobFunc;
        tblVec[freeIdx]   <= jobVec;
      end
      if (strb.pndDone && clrQ) begin
        tblValid[idxQ] <= 1'b0;
        tblDue[idxQ]   <= 1'b0;
      end
    end
  end

  a_r3_pnd_held: assert property (@(posedge clk) disable iff (!rstN)
    pndWrite && !pndReady |=> pndWrite);
  a_r3_pnd_once: assert property (@(posedge clk) disable iff (!rstN)
    pndWrite && pndReady |=> !pndWrite);
  a_r6_tx_held: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid);
  a_r5_drop_port: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !portOk |=> stateQ == ST_IDLE);
  a_r2_cfg_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |=> !cfgReq);
endmodule

// File: rtl/msi_pending_sequencer.sv
module msi_pending_sequencer
  import msi_seq_pkg::*;
#(
  parameter int TBL_DEPTH = 8,
  parameter int NUM_PORTS = 2,
  parameter int MIN_GAP   = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic [1:0]   reqPort,
  input  logic [2:0]   reqFunc,
  input  logic [4:0]   reqVec,
  input  logic [7:0]   pollGap,
  output logic         cfgReq,
  output logic [2:0]   cfgFunc,
  input  logic         cfgRspValid,
  input  logic [63:0]  cfgRspAddr,
  input  logic [31:0]  cfgRspData,
  input  logic [31:0]  cfgRspMask,
  output logic         pndWrite,
  input  logic         pndReady,
  output logic [2:0]   pndFunc,
  output logic [1:0]   pndSel,
  output logic [7:0]   pndByte,
  output logic         txValid,
  input  logic         txReady,
  output logic         txSop,
  output logic         txEop,
  output logic [2:0]   txLen,
  output logic [159:0] txData
);
  seqStrobe_t        strb;
  logic              rspMaskBit;
  logic [FUNC_W-1:0] jobFunc;
  logic [VEC_W-1:0]  jobVec;

  msi_seq_ctl #(.TBL_DEPTH(TBL_DEPTH), .NUM_PORTS(NUM_PORTS), .GAP_W(8), .MIN_GAP(MIN_GAP)) ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqPort(reqPort),
    .reqFunc(reqFunc), .reqVec(reqVec), .pollGap(pollGap), .cfgRspValid(cfgRspValid),
    .rspMaskBit(rspMaskBit), .jobFunc(jobFunc), .jobVec(jobVec), .pndReady(pndReady),
    .txReady(txReady), .cfgReq(cfgReq), .pndWrite(pndWrite), .txValid(txValid), .strb(strb)
  );

  msi_seq_dp dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgRspAddr(cfgRspAddr), .cfgRspData(cfgRspData),
    .cfgRspMask(cfgRspMask), .rspMaskBit(rspMaskBit), .jobFunc(jobFunc), .jobVec(jobVec),
    .pndSel(pndSel), .pndByte(pndByte), .txData(txData), .txLen(txLen)
  );

  assign cfgFunc = jobFunc;
  assign pndFunc = jobFunc;
  assign txSop   = txValid;
  assign txEop   = txValid;

  a_r3_pnd_stable: assert property (@(posedge clk) disable iff (!rstN)
    pndWrite && !pndReady |=> $stable({pndFunc, pndSel, pndByte}));
  a_r6_tx_stable: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> $stable({txLen, txData}));
endmodule

// File: tb/msi_pending_sequencer_test.sv
module msi_pending_sequencer_test;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqReady;
  logic [1:0] reqPort = 0;
  logic [2:0] reqFunc = 0;
  logic [4:0] reqVec = 0;
  logic [7:0] pollGap = 8'd20;
  logic cfgReq, cfgRspValid = 0;
  logic [2:0] cfgFunc;
  logic [63:0] cfgRspAddr = 0;
  logic [31:0] cfgRspData = 0, cfgRspMask = 0;
  logic pndWrite, pndReady = 1;
  logic [2:0] pndFunc;
  logic [1:0] pndSel;
  logic [7:0] pndByte;
  logic txValid, txReady = 1, txSop, txEop;
  logic [2:0] txLen;
  logic [159:0] txData;

  always #5 clk = ~clk;

  msi_pending_sequencer uut (.*);

  // configuration model
  logic [63:0] mAddr [8];
  logic [31:0] mData [8];
  logic [31:0] mMask [8];
  logic [2:0]  rspFunc;
  bit          rspDly;
  // logs
  int txCnt = 0, pndCnt = 0, cfgCnt = 0, evCnt = 0;
  logic [159:0] txLog [64];
  logic [2:0]   txLenLog [64];
  logic [12:0]  pndLog [64];
  int           evKind [128];
  int checks = 0, errors = 0;

  always @(negedge clk) begin
    if (rspDly) begin
      cfgRspValid = 1; cfgRspAddr = mAddr[rspFunc];
      cfgRspData = mData[rspFunc]; cfgRspMask = mMask[rspFunc]; rspDly = 0;
    end else cfgRspValid = 0;
    if (rstN && cfgReq) begin rspFunc = cfgFunc; rspDly = 1; cfgCnt++; end
    if (rstN && txValid && txReady && txCnt < 64) begin
      txLog[txCnt] = txData; txLenLog[txCnt] = txLen; txCnt++;
      if (evCnt < 128) begin evKind[evCnt] = 2; evCnt++; end
    end
    if (rstN && pndWrite && pndReady && pndCnt < 64) begin
      pndLog[pndCnt] = {pndFunc, pndSel, pndByte}; pndCnt++;
      if (evCnt < 128) begin evKind[evCnt] = 1; evCnt++; end
    end
  end

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [159:0] expTlp(logic [2:0] f, logic [63:0] a, logic [31:0] d);
    logic [31:0] h1 = {13'd0, f, 16'h000F};
    if (a[63:32] == 0) return {64'd0, d, a[31:2], 2'b00, h1, 32'h4000_0001};
    return {d, a[31:2], 2'b00, a[63:32], h1, 32'h6000_0001};
  endfunction

  task automatic sendReq(input logic [1:0] p, input logic [2:0] f, input logic [4:0] v);
    @(posedge clk); #1;
    reqValid = 1; reqPort = p; reqFunc = f; reqVec = v;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic waitTx(input int n, input int lim);
    for (int k = 0; k < lim && txCnt < n; k++) @(negedge clk);
  endtask
  task automatic waitPnd(input int n, input int lim);
    for (int k = 0; k < lim && pndCnt < n; k++) @(negedge clk);
  endtask

  // func, vec, address, data
  localparam logic [103:0] VECS [4] = '{
    {3'd0, 5'd0,  64'h0000_0000_FEE0_0000, 32'h0000_4021},
    {3'd7, 5'd31, 64'h0000_0001_2345_6788, 32'h0000_ABCD},
    {3'd3, 5'd8,  64'h0000_0000_FEE0_1004, 32'h1234_0077},
    {3'd1, 5'd17, 64'hFFFF_0000_0000_0010, 32'h0000_5A5A}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, p0, c0;
    logic [12:0] held;
    logic [159:0] heldTx, e;
    for (int f = 0; f < 8; f++) begin
      mAddr[f] = 64'hFEE0_0000 + 64'(f * 16); mData[f] = 32'h100 + f; mMask[f] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // reset state
    check(txValid == 0, "R6 reset txValid", 160'(txValid), 0);
    check(pndWrite == 0, "R3 reset pndWrite", 160'(pndWrite), 0);
    check(cfgReq == 0, "R2 reset cfgReq", 160'(cfgReq), 0);
    check(reqReady == 1, "R9 reset reqReady", 160'(reqReady), 1);

    // table of unmasked requests (R1, R6)
    for (int i = 0; i < 4; i++) begin
      logic [2:0] f = VECS[i][103:101];
      mAddr[f] = VECS[i][95:32]; mData[f] = VECS[i][31:0];
      t0 = txCnt; p0 = pndCnt;
      sendReq(2'(i % 2), f, VECS[i][100:96]);
      waitTx(t0 + 1, 40);
      e = expTlp(f, VECS[i][95:32], VECS[i][31:0]);
      check(txCnt == t0 + 1, "R1 one TLP", 160'(txCnt), 160'(t0 + 1));
      check(txLog[t0] == e, "R6 TLP content", txLog[t0], e);
      check(txLenLog[t0] == (VECS[i][95:64] == 0 ? 3'd4 : 3'd5), "R6 length",
            160'(txLenLog[t0]), 160'(VECS[i][95:64] == 0 ? 4 : 5));
      repeat (5) @(negedge clk);
      check(pndCnt == p0, "R1 no pending write", 160'(pndCnt), 160'(p0));
    end

    // bad port dropped (R5)
    t0 = txCnt; p0 = pndCnt; c0 = cfgCnt;
    sendReq(2'd2, 3'd4, 5'd1);
    sendReq(2'd3, 3'd4, 5'd2);
    repeat (40) @(negedge clk);
    check(cfgCnt == c0 && txCnt == t0 && pndCnt == p0, "R5 rejected port",
          160'(cfgCnt + txCnt + pndCnt), 160'(c0 + t0 + p0));

    // masked vector, pending port stalled (R2, R3)
    mMask[2] = (32'd1 << 10) | (32'd1 << 13);
    mData[2] = 32'hC0DE_0002; mAddr[2] = 64'hFEE0_2000;
    @(posedge clk); #1 pndReady = 0;
    t0 = txCnt; p0 = pndCnt;
    sendReq(2'd0, 3'd2, 5'd10);
    for (int k = 0; k < 40 && !pndWrite; k++) @(negedge clk);
    held = {pndFunc, pndSel, pndByte};
    repeat (4) @(negedge clk);
    check(pndWrite && {pndFunc, pndSel, pndByte} == held, "R3 held while not ready",
          160'({pndWrite, pndFunc, pndSel, pndByte}), 160'({1'b1, held}));
    @(posedge clk); #1 pndReady = 1;
    waitPnd(p0 + 1, 20);
    check(pndLog[p0] == {3'd2, 2'd1, 8'h04}, "R3 set byte fields", 160'(pndLog[p0]), 160'({3'd2, 2'd1, 8'h04}));
    @(negedge clk);
    check(!pndWrite, "R3 single cycle write", 160'(pndWrite), 0);

    // second vector in same byte (R4)
    sendReq(2'd1, 3'd2, 5'd13);
    waitPnd(p0 + 2, 40);
    check(pndLog[p0 + 1] == {3'd2, 2'd1, 8'h24}, "R4 merged set byte", 160'(pndLog[p0 + 1]), 160'({3'd2, 2'd1, 8'h24}));

    // polling rate with too-small gap (R7)
    @(posedge clk); #1 pollGap = 8'd4;
    c0 = cfgCnt;
    repeat (320) @(negedge clk);
    check(cfgCnt - c0 <= 42 && cfgCnt - c0 >= 20, "R7 poll rate", 160'(cfgCnt - c0), 160'(42));
    check(txCnt == t0, "R2 no TLP while masked", 160'(txCnt), 160'(t0));
    @(posedge clk); #1 pollGap = 8'd20;

    // duplicate merged (R8)
    p0 = pndCnt;
    sendReq(2'd0, 3'd2, 5'd10);
    repeat (60) @(negedge clk);
    check(txCnt == t0 && pndCnt == p0, "R8 duplicate merged", 160'(txCnt + pndCnt), 160'(t0 + p0));

    // unmasked served while others wait (R9)
    mMask[5] = 0; mAddr[5] = 64'hFEE0_5000; mData[5] = 32'h55;
    sendReq(2'd1, 3'd5, 5'd0);
    waitTx(t0 + 1, 60);
    e = expTlp(3'd5, 64'hFEE0_5000, 32'h55);
    check(txCnt == t0 + 1 && txLog[t0] == e, "R9 served while waiting", txLog[t0], e);

    // unmask vector 10 (R2, R4)
    p0 = pndCnt; t0 = txCnt; c0 = evCnt;
    mMask[2] = 32'd1 << 13;
    waitPnd(p0 + 1, 200);
    e = expTlp(3'd2, 64'hFEE0_2000, 32'hC0DE_0002);
    check(txCnt == t0 + 1 && txLog[t0] == e, "R2 TLP after unmask", txLog[t0], e);
    check(pndLog[p0] == {3'd2, 2'd1, 8'h20}, "R4 clear keeps neighbour", 160'(pndLog[p0]), 160'({3'd2, 2'd1, 8'h20}));
    check(evKind[c0] == 2 && evKind[c0 + 1] == 1, "R2 TLP before clear",
          160'({evKind[c0], evKind[c0 + 1]}), 160'({32'd2, 32'd1}));

    // unmask vector 13 (R2)
    mMask[2] = 0;
    waitPnd(p0 + 2, 200);
    check(pndLog[p0 + 1] == {3'd2, 2'd1, 8'h00}, "R2 final clear", 160'(pndLog[p0 + 1]), 160'({3'd2, 2'd1, 8'h00}));

    // transmit backpressure (R6)
    mMask[4] = 0; mAddr[4] = 64'h0000_0002_0000_0040; mData[4] = 32'h4444;
    @(posedge clk); #1 txReady = 0;
    t0 = txCnt;
    sendReq(2'd0, 3'd4, 5'd3);
    for (int k = 0; k < 40 && !txValid; k++) @(negedge clk);
    heldTx = txData;
    repeat (4) @(negedge clk);
    check(txValid && txSop && txEop && txData == heldTx, "R6 held under backpressure", txData, heldTx);
    @(posedge clk); #1 txReady = 1;
    waitTx(t0 + 1, 20);
    e = expTlp(3'd4, 64'h0000_0002_0000_0040, 32'h4444);
    check(txLog[t0] == e && txLenLog[t0] == 3'd5, "R6 wide address TLP", txLog[t0], e);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule